// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex serial port that generates its own serial clock. A byte written into the transmit holding register moves into a shift register. Its bits leave on the data output one per serial clock period, least significant bit first. Each bit is launched when the serial clock falls. Bits on the data input are captured when the serial clock rises. After eight captures the assembled byte moves into a receive holding register and a full flag is raised.

Both directions have a holding register in front of the shifter. While one byte shifts, the next one waits, so a host that keeps the transmit buffer fed gets an unbroken stream of clock periods. The serial clock runs only while a byte is shifting, and it rests high between transfers. Reception uses those same rising edges but has its own shifter, counter and buffer, so the received data does not depend on the transmitted data. The half period of the serial clock is set by an 8-bit divisor.

Top module: `sync_serial_port`

## Requirements
- R1: Each transmitted byte appears on `sdo_o` as 8 bits, bit 0 first and bit 7 last. Each bit is the value of `sdo_o` at one rising edge of `sclk_o`.
- R2: `sdo_o` changes only at the same system clock edge where `sclk_o` falls. It is stable while `sclk_o` is high and across each rising edge.
- R3: While shifting, every low phase of `sclk_o` lasts exactly `div_i`+1 system clock cycles. When no byte is shifting, `sclk_o` is high.
- R4: `sdi_i` is sampled at each rising edge of `sclk_o`, bit 0 first. At the eighth sample the byte appears on `rx_data_o` and `rx_full_o` goes to 1.
- R5: A `tx_wr_i` pulse while `tx_empty_o` is 1 clears `tx_empty_o` in the next cycle. If the shifter is idle, the byte moves into the shifter one cycle later and `tx_empty_o` returns to 1.
- R6: When the buffer is refilled before the current byte ends, N bytes take exactly (16·N−1)·(`div_i`+1) system clock cycles. This is measured from the first falling edge of `sclk_o` to the last rising edge, with no idle period between bytes.
- R7: A `tx_wr_i` pulse while `tx_empty_o` is 0 is ignored, and that byte is never transmitted.
- R8: A byte that completes while `rx_full_o` is 1 and `rx_rd_i` is 0 sets `overrun_o` and leaves `rx_data_o` unchanged. `overrun_o` stays set until an `ovr_clr_i` pulse.
- R9: `rx_full_o` stays 1 until an `rx_rd_i` pulse, which clears it in the next cycle.
- R10: After the last byte, `sclk_o` stays high and `sdo_o` holds that byte's bit 7.
- R11: The received bytes depend only on `sdi_i`, so both directions carry unrelated data at the same time.
- R12: After reset, `sclk_o`=1, `sdo_o`=1, `tx_empty_o`=1, `rx_full_o`=0 and `overrun_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_i | input | 8 | Serial clock half period minus one, in system clocks |
| tx_data_i | input | 8 | Byte to transmit |
| tx_wr_i | input | 1 | Write strobe for the transmit buffer |
| tx_empty_o | output | 1 | Transmit buffer can accept a byte |
| rx_data_o | output | 8 | Last received byte |
| rx_full_o | output | 1 | Receive buffer holds an unread byte |
| rx_rd_i | input | 1 | Read acknowledge, clears the full flag |
| overrun_o | output | 1 | A byte was lost because the buffer was full |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
A write to an idle port clears `tx_empty_o` one cycle later. The first falling edge of `sclk_o` and the return of `tx_empty_o` come one cycle after that. Each serial edge then follows `div_i`+1 cycles after the one before it. `rx_full_o` rises in the same cycle as the eighth rising edge. A read strobe or an overrun clear takes effect one cycle later.

The bench drives inputs on falling system clock edges and samples on the next falling edge. An edge monitor timestamps every `sclk_o` transition by cycle count. From these timestamps it checks the low phase lengths and the total stream duration arithmetically. The sweep sends every byte value in loopback at the fastest divisor.

// File: rtl/ssp_pkg.sv
// Package: shared constants for the synchronous serial port.
// Assumes the character width is a power of two.
package ssp_pkg;
    localparam int SSP_CHAR_W = 8;
    localparam int SSP_DIV_W  = 8;
endpackage

// File: rtl/ssp_clkgen.sv
// Module: half-period tick generator for the serial clock.
// Emits a one-cycle tick every div_i+1 system clocks while run_i is high.
// Assumes: counter restarts from zero whenever run_i is low.
module ssp_clkgen #(
    parameter int DIV_W = ssp_pkg::SSP_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    // Tick when the count reaches the divisor.
    assign tick_o = run_i && (cnt_q == div_i);

    // Count system clocks within one serial half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ssp_txbuf.sv
// Module: transmit holding register.
// Accepts a byte only when empty; the shifter drains it via take_i.
// Assumes: take_i is only asserted while full_o is high.
module ssp_txbuf #(
    parameter int DATA_W = ssp_pkg::SSP_CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              take_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);
    // Hold one pending byte; writes while full are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_o <= 1'b0;
            data_o <= '0;
        end else if (take_i) begin
            full_o <= 1'b0;
        end else if (wr_i && !full_o) begin
            full_o <= 1'b1;
            data_o <= data_i;
        end
    end
endmodule

// File: rtl/ssp_txshift.sv
// Module: transmit shifter and serial clock phase control.
// Launches each bit on the falling serial edge, LSB first, and reloads
// from the holding register right after the last rising edge of a byte.
// Assumes: tick_i marks the end of each serial half period.
module ssp_txshift #(
    parameter int DATA_W = ssp_pkg::SSP_CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              buf_full_i,
    input  logic [DATA_W-1:0] buf_data_i,
    output logic              take_o,
    output logic              rise_o,
    output logic              busy_o,
    output logic              sclk_o,
    output logic              sdo_o
);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BW-1:0] LAST = BW'(DATA_W - 1);

    logic [DATA_W-1:0] sh_q;
    logic [BW-1:0]     bit_q;
    logic              end_of_char;

    // Byte finishes at the half-period end after its last rising edge.
    assign end_of_char = busy_o && tick_i && sclk_o && (bit_q == LAST);
    // Load from the buffer when idle or at a byte boundary.
    assign take_o      = buf_full_i && (!busy_o || end_of_char);
    // Serial clock rises at the end of a low phase.
    assign rise_o      = busy_o && tick_i && !sclk_o;

    // Advance serial clock phase and shift out data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            bit_q  <= '0;
            busy_o <= 1'b0;
            sclk_o <= 1'b1;
            sdo_o  <= 1'b1;
        end else if (take_o) begin
            sh_q   <= buf_data_i;
            sdo_o  <= buf_data_i[0];
            bit_q  <= '0;
            busy_o <= 1'b1;
            sclk_o <= 1'b0;
        end else if (busy_o && tick_i) begin
            if (!sclk_o) begin
                sclk_o <= 1'b1;
            end else if (bit_q == LAST) begin
                busy_o <= 1'b0;
            end else begin
                bit_q  <= bit_q + 1'b1;
                sh_q   <= sh_q >> 1;
                sdo_o  <= sh_q[1];
                sclk_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ssp_rx.sv
// Module: receive shifter, holding register and overrun flag.
// Samples sdi_i at each rising serial edge, LSB first.
// Assumes: rise_i is a single-cycle pulse per rising serial edge.
module ssp_rx #(
    parameter int DATA_W = ssp_pkg::SSP_CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              sdi_i,
    input  logic              rd_i,
    input  logic              ovr_clr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              ovr_o
);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BW-1:0] LAST = BW'(DATA_W - 1);

    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] next_char;
    logic [BW-1:0]     bit_q;
    logic              done;

    // The incoming bit enters at the top so bit 0 ends at the bottom.
    assign next_char = {sdi_i, sh_q[DATA_W-1:1]};
    assign done      = rise_i && (bit_q == LAST);

    // Shift in one bit per rising serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            bit_q <= '0;
        end else if (rise_i) begin
            sh_q  <= next_char;
            bit_q <= (bit_q == LAST) ? '0 : bit_q + 1'b1;
        end
    end

    // Transfer completed bytes unless the buffer is still unread.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            full_o <= 1'b0;
        end else if (done && (!full_o || rd_i)) begin
            data_o <= next_char;
            full_o <= 1'b1;
        end else if (rd_i) begin
            full_o <= 1'b0;
        end
    end

    // Record a byte lost to a full buffer; set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_o <= 1'b0;
        end else if (done && full_o && !rd_i) begin
            ovr_o <= 1'b1;
        end else if (ovr_clr_i) begin
            ovr_o <= 1'b0;
        end
    end
endmodule

// File: rtl/sync_serial_port.sv
// Module: full-duplex clocked serial port, master clock, LSB first.
// Transmit and receive are each double-buffered; the serial clock runs
// only while a byte shifts and idles high.
// Assumes: div_i is changed only while the port is idle.
module sync_serial_port #(
    parameter int DATA_W = ssp_pkg::SSP_CHAR_W,
    parameter int DIV_W  = ssp_pkg::SSP_DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_wr_i,
    output logic              tx_empty_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_full_o,
    input  logic              rx_rd_i,
    output logic              overrun_o,
    input  logic              ovr_clr_i,
    output logic              sclk_o,
    output logic              sdo_o,
    input  logic              sdi_i
);
    logic              tick;
    logic              tx_busy;
    logic              take;
    logic              rise;
    logic              buf_full;
    logic [DATA_W-1:0] buf_data;

    assign tx_empty_o = !buf_full;

    ssp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run_i(tx_busy), .div_i(div_i), .tick_o(tick)
    );

    ssp_txbuf #(.DATA_W(DATA_W)) u_txbuf (
        .clk(clk), .rst_n(rst_n), .wr_i(tx_wr_i), .data_i(tx_data_i),
        .take_i(take), .full_o(buf_full), .data_o(buf_data)
    );

    ssp_txshift #(.DATA_W(DATA_W)) u_txshift (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .buf_full_i(buf_full),
        .buf_data_i(buf_data), .take_o(take), .rise_o(rise), .busy_o(tx_busy),
        .sclk_o(sclk_o), .sdo_o(sdo_o)
    );

    ssp_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .sdi_i(sdi_i), .rd_i(rx_rd_i),
        .ovr_clr_i(ovr_clr_i), .data_o(rx_data_o), .full_o(rx_full_o),
        .ovr_o(overrun_o)
    );
endmodule

// File: rtl/ssp_checker.sv
// Module: temporal properties of the serial port, bound to the top.
module ssp_checker #(
    parameter int DATA_W = ssp_pkg::SSP_CHAR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              sclk_o,
    input logic              sdo_o,
    input logic              tx_wr_i,
    input logic              tx_empty_o,
    input logic [DATA_W-1:0] rx_data_o,
    input logic              rx_full_o,
    input logic              rx_rd_i,
    input logic              overrun_o
);
    // R3: clock rests high whenever no byte is shifting.
    p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk_o);

    // R2: data holds through the high phase.
    p_hold_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

    // R2: data does not move on a rising serial edge.
    p_hold_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(sdo_o));

    // R5: accepted write clears the empty flag next cycle.
    p_empty_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_i && tx_empty_o) |=> !tx_empty_o);

    // R9: full flag persists until read.
    p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full_o && !rx_rd_i) |=> rx_full_o);

    // R8: raising the overrun flag leaves the buffered byte alone.
    p_keep_on_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> $stable(rx_data_o));
endmodule

bind sync_serial_port ssp_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(tx_busy), .sclk_o(sclk_o), .sdo_o(sdo_o),
    .tx_wr_i(tx_wr_i), .tx_empty_o(tx_empty_o), .rx_data_o(rx_data_o),
    .rx_full_o(rx_full_o), .rx_rd_i(rx_rd_i), .overrun_o(overrun_o)
);

// File: tb/tb_sync_serial_port.sv
module tb_sync_serial_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_i = 8'd0;
    logic [7:0] tx_data_i = 8'd0;
    logic       tx_wr_i = 1'b0;
    logic       tx_empty_o;
    logic [7:0] rx_data_o;
    logic       rx_full_o;
    logic       rx_rd_i = 1'b0;
    logic       overrun_o;
    logic       ovr_clr_i = 1'b0;
    logic       sclk_o;
    logic       sdo_o;
    logic       sdi_i;
    logic       sdi_drv = 1'b0;
    logic       loop_mode = 1'b1;

    int cyc = 0;
    int nchecks = 0, nfail = 0;
    int mchecks = 0, mfail = 0;
    int cur_div = 0;
    int mon_n = 0, mbit = 0, last_chg = 0;
    logic       prev_sclk = 1'b1;
    logic [7:0] msh = 8'd0;
    logic [7:0] mon_b [0:511];
    int         st_t  [0:511];
    int         en_t  [0:511];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign sdi_i = loop_mode ? sdo_o : sdi_drv;

    sync_serial_port dut (
        .clk(clk), .rst_n(rst_n), .div_i(div_i), .tx_data_i(tx_data_i),
        .tx_wr_i(tx_wr_i), .tx_empty_o(tx_empty_o), .rx_data_o(rx_data_o),
        .rx_full_o(rx_full_o), .rx_rd_i(rx_rd_i), .overrun_o(overrun_o),
        .ovr_clr_i(ovr_clr_i), .sclk_o(sclk_o), .sdo_o(sdo_o), .sdi_i(sdi_i)
    );

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Edge monitor: timestamps serial edges, captures sdo, drives sdi.
    always @(negedge clk) begin
        if (rst_n && (sclk_o !== prev_sclk)) begin
            if (!sclk_o) begin
                logic [7:0] p;
                if (mbit == 0) st_t[mon_n] = cyc;
                p = pat(mon_n);
                sdi_drv = p[mbit];
            end else begin
                mchecks++;
                if (cyc - last_chg != cur_div + 1) begin
                    mfail++;
                    $display("FAIL R3 low phase actual=%0d expected=%0d",
                             cyc - last_chg, cur_div + 1);
                end
                msh[mbit] = sdo_o;
                mbit++;
                if (mbit == 8) begin
                    mon_b[mon_n] = msh;
                    en_t[mon_n]  = cyc;
                    mon_n++;
                    mbit = 0;
                end
            end
            last_chg  = cyc;
            prev_sclk = sclk_o;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Stream n bytes, reading every received byte, then check everything.
    task automatic run_stream(input int div, input int n, input bit loop,
                              input int mul, input int add);
        int sent = 0, got = 0, guard = 0, base;
        logic [7:0] tb_byte, exp;
        @(negedge clk);
        cur_div = div; div_i = 8'(div); loop_mode = loop;
        base = mon_n;
        while (got < n && guard < 60000) begin
            tx_wr_i = 1'b0; rx_rd_i = 1'b0;
            if (sent < n && tx_empty_o) begin
                tx_data_i = 8'((sent * mul + add) & 255);
                tx_wr_i = 1'b1;
                sent++;
            end
            if (rx_full_o) begin
                exp = loop ? 8'((got * mul + add) & 255) : pat(base + got);
                // R4 / R11: received byte matches the line data.
                chk(rx_data_o == exp, loop ? "R4 loopback byte" : "R11 duplex byte",
                    rx_data_o, exp);
                rx_rd_i = 1'b1;
                got++;
            end
            guard++;
            @(negedge clk);
        end
        tx_wr_i = 1'b0; rx_rd_i = 1'b0;
        idle(4 * (div + 1) + 4);
        chk(got == n, "R4 byte count", got, n);
        for (int k = 0; k < n; k++) begin
            tb_byte = 8'((k * mul + add) & 255);
            // R1: serial bits, LSB first, reproduce each written byte.
            chk(mon_b[base + k] == tb_byte, "R1 serial byte", mon_b[base + k], tb_byte);
        end
        // R6: no idle period anywhere in the stream.
        chk(en_t[base + n - 1] - st_t[base] == (16 * n - 1) * (div + 1),
            "R6 stream length", en_t[base + n - 1] - st_t[base], (16 * n - 1) * (div + 1));
        // R10: idle clock high, data holds bit 7 of the last byte.
        tb_byte = 8'(((n - 1) * mul + add) & 255);
        chk(sclk_o == 1'b1, "R10 idle sclk", sclk_o, 1);
        chk(sdo_o == tb_byte[7], "R10 idle sdo", sdo_o, tb_byte[7]);
        chk(overrun_o == 1'b0, "R8 no overrun when read", overrun_o, 0);
    endtask

    initial begin
        int guard;
        int got;
        int base;
        logic [7:0] seen [0:7];
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state.
        chk(sclk_o == 1'b1, "R12 sclk", sclk_o, 1);
        chk(sdo_o == 1'b1, "R12 sdo", sdo_o, 1);
        chk(tx_empty_o == 1'b1, "R12 tx_empty", tx_empty_o, 1);
        chk(rx_full_o == 1'b0, "R12 rx_full", rx_full_o, 0);
        chk(overrun_o == 1'b0, "R12 overrun", overrun_o, 0);

        // Exhaustive byte sweep, fastest divisor, loopback.
        run_stream(0, 256, 1'b1, 1, 0);
        // Independent receive data at a slower divisor.
        run_stream(2, 20, 1'b0, 29, 3);
        run_stream(1, 8, 1'b1, 71, 200);

        // Overrun scenario (R5, R8, R9, R10).
        cur_div = 0; div_i = 8'd0; loop_mode = 1'b1;
        tx_data_i = 8'hA5; tx_wr_i = 1'b1;
        @(negedge clk); tx_wr_i = 1'b0;
        chk(tx_empty_o == 1'b0, "R5 empty drops", tx_empty_o, 0);
        @(negedge clk);
        chk(tx_empty_o == 1'b1, "R5 empty returns on load", tx_empty_o, 1);
        tx_data_i = 8'h5A; tx_wr_i = 1'b1;
        @(negedge clk); tx_wr_i = 1'b0;
        idle(60);
        chk(rx_full_o == 1'b1, "R8 full kept", rx_full_o, 1);
        chk(rx_data_o == 8'hA5, "R8 old byte kept", rx_data_o, 8'hA5);
        chk(overrun_o == 1'b1, "R8 overrun set", overrun_o, 1);
        chk(sclk_o == 1'b1, "R10 idle sclk", sclk_o, 1);
        chk(sdo_o == 1'b0, "R10 idle sdo bit7", sdo_o, 0);
        rx_rd_i = 1'b1;
        @(negedge clk); rx_rd_i = 1'b0;
        chk(rx_full_o == 1'b0, "R9 read clears full", rx_full_o, 0);
        chk(overrun_o == 1'b1, "R8 overrun persists", overrun_o, 1);
        ovr_clr_i = 1'b1;
        @(negedge clk); ovr_clr_i = 1'b0;
        chk(overrun_o == 1'b0, "R8 overrun cleared", overrun_o, 0);

        // Write while buffer full is dropped (R7).
        cur_div = 3; div_i = 8'd3;
        base = mon_n;
        tx_data_i = 8'h81; tx_wr_i = 1'b1;
        @(negedge clk); tx_wr_i = 1'b0;
        guard = 0;
        while (!tx_empty_o && guard < 50) begin @(negedge clk); guard++; end
        tx_data_i = 8'h42; tx_wr_i = 1'b1;
        @(negedge clk);
        chk(tx_empty_o == 1'b0, "R7 buffer full", tx_empty_o, 0);
        tx_data_i = 8'hFF;
        @(negedge clk); tx_wr_i = 1'b0;
        got = 0;
        for (int i = 0; i < 400; i++) begin
            rx_rd_i = 1'b0;
            if (rx_full_o) begin
                if (got < 8) seen[got] = rx_data_o;
                got++;
                rx_rd_i = 1'b1;
            end
            @(negedge clk);
        end
        rx_rd_i = 1'b0;
        chk(got == 2, "R7 received count", got, 2);
        chk(mon_n - base == 2, "R7 serial byte count", mon_n - base, 2);
        chk(seen[0] == 8'h81, "R7 first byte", seen[0], 8'h81);
        chk(seen[1] == 8'h42, "R7 second byte", seen[1], 8'h42);

        $display("%0d/%0d checks passed", (nchecks + mchecks) - (nfail + mfail),
                 nchecks + mchecks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        nchecks++; nfail++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("%0d/%0d checks passed", (nchecks + mchecks) - (nfail + mfail),
                 nchecks + mchecks);
        $finish;
    end
endmodule